// File: doc/BRIEF.md
# Ideal-Device Frame Latency Calculator

This block measures the delay that a device under test adds to one multi-cell frame. The arrival pattern of the cells is not counted as part of that delay. The input side gives a strobe at the first bit of every arriving cell, along with start-of-frame and end-of-frame markers. The output side gives a strobe at the last bit of every departing cell. Each strobe carries a timestamp taken from one shared free-running tick counter. The timestamps are inputs to the block; it does not capture them.

As cells arrive, the block tracks, in real time, when a zero-delay device would have finished sending the frame. That device sends each cell as soon as the cell has started arriving and the previous cell has left. The per-cell time is the larger of the input cell time and the output cell time, both given in ticks as parameters. When the frame is complete, the block reports three values in the same one-cycle pulse:

- the measured first-in to last-out latency;
- the ideal-device latency;
- their difference, which is the device's own contribution.

Top module: `ideal_lat_calc`

## Requirements
- R1: The ideal latency starts at zero. For every accepted input cell of a frame it becomes max(t, ideal) + max(CIT_TICKS, COT_TICKS), where t is that cell's timestamp minus the timestamp of the frame's first cell (0 for the first cell).
- R2: res_measured equals the timestamp of the last accepted output cell end minus the timestamp of the frame's first input cell.
- R3: res_device equals res_measured minus res_ideal. If that difference would be negative, res_device is 0 and res_underflow is 1; otherwise res_underflow is 0.
- R4: With CIT_TICKS=1 and COT_TICKS=4, a two-cell frame arriving at relative ticks 0 and 5 gives an ideal latency of 9. Arrivals at 0 and 2 give 8.
- R5: With CIT_TICKS >= COT_TICKS, and with the last cell not waiting behind an earlier one, res_device equals the last output end timestamp minus (last input start timestamp + CIT_TICKS).
- R6: A frame closes once its end-of-frame input cell has been accepted and the number of accepted output cell ends equals the number of accepted input cells. If the closing output end is sampled at clock edge k, res_valid is high for exactly the one cycle that follows edge k+1.
- R7: in_cell_start with in_sof=1 while a frame is open sets overlap_err. This includes the cycle in which the result is being issued. overlap_err stays set until reset, and the offending cell is not counted.
- R8: The following are ignored: input cells without in_sof while no frame is open, input cells after the end-of-frame cell, and output ends when no frame is open or when outputs already equal inputs. None of them produces a pulse or changes a result.
- R9: Reset (rst=1, synchronous) clears res_valid, overlap_err, res_underflow and all result values to 0.
- R10: All timestamp arithmetic is modulo 2^32, so a frame that spans a wrap of the tick counter reports correct values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_cell_start | input | 1 | First bit of an input cell arrives this cycle |
| in_sof | input | 1 | The input cell starts a frame |
| in_eof | input | 1 | The input cell ends a frame |
| in_ts | input | 32 | Tick timestamp of the input strobe |
| out_cell_end | input | 1 | Last bit of an output cell leaves this cycle |
| out_ts | input | 32 | Tick timestamp of the output strobe |
| res_valid | output | 1 | One-cycle result pulse |
| res_measured | output | 32 | First-in to last-out latency in ticks |
| res_ideal | output | 32 | Zero-delay device latency in ticks |
| res_device | output | 32 | Device contribution, saturated at 0 |
| res_underflow | output | 1 | The difference was negative |
| overlap_err | output | 1 | Sticky: a frame start arrived during an open frame |

## Verification
The bench builds two copies of the block from the same stimulus.

- One copy has CIT_TICKS=1 and COT_TICKS=4, an input four times faster than the output. It reaches the waiting and non-waiting cases of the recurrence and the worked values 9 and 8.
- The other copy has CIT_TICKS=4 and COT_TICKS=1, a slower input. It reaches the last-bit-in to last-bit-out equality.

Both copies have the same per-cell maximum, so one queue-based reference model predicts both on every clock. The tick counter starts just below its wrap point, so the first frame spans the rollover.

// File: rtl/ilc_pkg.sv
package ilc_pkg;

    localparam int TS_W = 32;

    typedef logic [TS_W-1:0] ts_t;

    // Per-cycle decisions taken by the frame controller
    typedef struct packed {
        logic start_frame;
        logic add_cell;
        logic take_out;
        logic finish;
    } frame_evt_t;

    typedef struct packed {
        ts_t  measured;
        ts_t  ideal;
        ts_t  device;
        logic underflow;
    } lat_result_t;

    function automatic ts_t ts_max(input ts_t a, input ts_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic lat_result_t make_result(input ts_t first_in,
                                                input ts_t last_out,
                                                input ts_t ideal);
        lat_result_t r;
        r.measured  = last_out - first_in;
        r.ideal     = ideal;
        r.underflow = (r.measured < ideal);
        r.device    = r.underflow ? '0 : (r.measured - ideal);
        return r;
    endfunction

endpackage

// File: rtl/ilc_frame_ctl.sv
module ilc_frame_ctl
    import ilc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_cell_start,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic       out_cell_end,
    output frame_evt_t evt,
    output logic       overlap_err
);

    logic             open_q;
    logic             eof_q;
    logic [CNT_W-1:0] in_cnt_q;
    logic [CNT_W-1:0] out_cnt_q;

    always_comb begin
        evt.finish      = open_q & eof_q & (in_cnt_q == out_cnt_q);
        evt.start_frame = in_cell_start & in_sof & ~open_q;
        evt.add_cell    = in_cell_start & ~in_sof & open_q & ~eof_q;
        evt.take_out    = out_cell_end & open_q & (out_cnt_q != in_cnt_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q      <= 1'b0;
            eof_q       <= 1'b0;
            in_cnt_q    <= '0;
            out_cnt_q   <= '0;
            overlap_err <= 1'b0;
        end else begin
            if (evt.start_frame) begin
                open_q    <= 1'b1;
                eof_q     <= in_eof;
                in_cnt_q  <= CNT_W'(1);
                out_cnt_q <= '0;
            end else begin
                if (evt.finish) begin
                    open_q <= 1'b0;
                end
                if (evt.add_cell) begin
                    in_cnt_q <= in_cnt_q + CNT_W'(1);
                    if (in_eof) begin
                        eof_q <= 1'b1;
                    end
                end
                if (evt.take_out) begin
                    out_cnt_q <= out_cnt_q + CNT_W'(1);
                end
            end
            if (in_cell_start && in_sof && open_q) begin
                overlap_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ilc_ideal_accum.sv
module ilc_ideal_accum
    import ilc_pkg::*;
#(
    parameter int unsigned CELL_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  frame_evt_t evt,
    input  ts_t        in_ts,
    output ts_t        frame_start,
    output ts_t        ideal_acc
);

    localparam ts_t STEP = ts_t'(CELL_TICKS);

    ts_t rel_arrival;

    always_comb begin
        rel_arrival = in_ts - frame_start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_start <= '0;
            ideal_acc   <= '0;
        end else if (evt.start_frame) begin
            frame_start <= in_ts;
            ideal_acc   <= STEP;
        end else if (evt.add_cell) begin
            ideal_acc   <= ts_max(rel_arrival, ideal_acc) + STEP;
        end
    end

endmodule

// File: rtl/ilc_out_track.sv
module ilc_out_track
    import ilc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_evt_t evt,
    input  ts_t        out_ts,
    output ts_t        last_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_out <= '0;
        end else if (evt.take_out) begin
            last_out <= out_ts;
        end
    end

endmodule

// File: rtl/ilc_result.sv
module ilc_result
    import ilc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  frame_evt_t  evt,
    input  ts_t         frame_start,
    input  ts_t         last_out,
    input  ts_t         ideal_acc,
    output logic        valid,
    output lat_result_t res
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            res   <= '0;
        end else begin
            valid <= evt.finish;
            if (evt.finish) begin
                res <= make_result(frame_start, last_out, ideal_acc);
            end
        end
    end

endmodule

// File: rtl/ideal_lat_calc.sv
module ideal_lat_calc
    import ilc_pkg::*;
#(
    parameter int unsigned CIT_TICKS = 1,
    parameter int unsigned COT_TICKS = 4,
    parameter int          CNT_W     = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_cell_start,
    input  logic            in_sof,
    input  logic            in_eof,
    input  logic [TS_W-1:0] in_ts,
    input  logic            out_cell_end,
    input  logic [TS_W-1:0] out_ts,
    output logic            res_valid,
    output logic [TS_W-1:0] res_measured,
    output logic [TS_W-1:0] res_ideal,
    output logic [TS_W-1:0] res_device,
    output logic            res_underflow,
    output logic            overlap_err
);

    localparam int unsigned CELL_TICKS = (CIT_TICKS > COT_TICKS) ? CIT_TICKS : COT_TICKS;

    frame_evt_t  evt;
    ts_t         frame_start;
    ts_t         ideal_acc;
    ts_t         last_out;
    lat_result_t res;

    ilc_frame_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk           (clk),
        .rst           (rst),
        .in_cell_start (in_cell_start),
        .in_sof        (in_sof),
        .in_eof        (in_eof),
        .out_cell_end  (out_cell_end),
        .evt           (evt),
        .overlap_err   (overlap_err)
    );

    ilc_ideal_accum #(.CELL_TICKS(CELL_TICKS)) u_acc (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .in_ts       (in_ts),
        .frame_start (frame_start),
        .ideal_acc   (ideal_acc)
    );

    ilc_out_track u_out (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .out_ts   (out_ts),
        .last_out (last_out)
    );

    ilc_result u_res (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .frame_start (frame_start),
        .last_out    (last_out),
        .ideal_acc   (ideal_acc),
        .valid       (res_valid),
        .res         (res)
    );

    assign res_measured  = res.measured;
    assign res_ideal     = res.ideal;
    assign res_device    = res.device;
    assign res_underflow = res.underflow;

endmodule

// File: rtl/ilc_checker.sv
module ilc_checker #(
    parameter int unsigned CIT_TICKS = 1,
    parameter int unsigned COT_TICKS = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        in_cell_start,
    input logic        in_sof,
    input logic        res_valid,
    input logic [31:0] res_measured,
    input logic [31:0] res_ideal,
    input logic [31:0] res_device,
    input logic        res_underflow,
    input logic        overlap_err
);

    localparam logic [31:0] CELL = (CIT_TICKS > COT_TICKS) ? CIT_TICKS : COT_TICKS;

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R7
    overlap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overlap_err |=> overlap_err);

    // R7
    overlap_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overlap_err) |-> $past(in_cell_start && in_sof));

    // R3
    sat_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_underflow) |-> (res_device == 32'd0 && res_measured < res_ideal));

    // R3
    diff_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_underflow) |-> (res_device + res_ideal == res_measured));

    // R1
    ideal_floor_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_ideal >= CELL));

    // R6
    results_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |=> (res_valid || $stable(res_ideal)));

endmodule

bind ideal_lat_calc ilc_checker #(.CIT_TICKS(CIT_TICKS), .COT_TICKS(COT_TICKS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_cell_start (in_cell_start),
    .in_sof        (in_sof),
    .res_valid     (res_valid),
    .res_measured  (res_measured),
    .res_ideal     (res_ideal),
    .res_device    (res_device),
    .res_underflow (res_underflow),
    .overlap_err   (overlap_err)
);

// File: tb/ideal_lat_calc_tb.sv
module ideal_lat_calc_tb;

    localparam logic [31:0] CELL = 32'd4;   // max(CIT, COT) for both copies

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_start = 1'b0, in_sof = 1'b0, in_eof = 1'b0, out_end = 1'b0;
    logic [31:0] tick = 32'hFFFF_FFF8;

    logic        a_v, a_uf, a_ov, b_v, b_uf, b_ov;
    logic [31:0] a_m, a_i, a_d, b_m, b_i, b_d;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;
    always @(negedge clk) tick <= tick + 32'd1;

    ideal_lat_calc #(.CIT_TICKS(1), .COT_TICKS(4)) u_dut (
        .clk(clk), .rst(rst), .in_cell_start(in_start), .in_sof(in_sof), .in_eof(in_eof),
        .in_ts(tick), .out_cell_end(out_end), .out_ts(tick),
        .res_valid(a_v), .res_measured(a_m), .res_ideal(a_i), .res_device(a_d),
        .res_underflow(a_uf), .overlap_err(a_ov));

    ideal_lat_calc #(.CIT_TICKS(4), .COT_TICKS(1)) u_dut_slow (
        .clk(clk), .rst(rst), .in_cell_start(in_start), .in_sof(in_sof), .in_eof(in_eof),
        .in_ts(tick), .out_cell_end(out_end), .out_ts(tick),
        .res_valid(b_v), .res_measured(b_m), .res_ideal(b_i), .res_device(b_d),
        .res_underflow(b_uf), .overlap_err(b_ov));

    // ---------------- reference model ----------------
    bit          m_open, m_eof;
    logic [31:0] m_q[$];
    int          m_nout;
    logic [31:0] m_start, m_last;
    bit          e_v, e_uf, e_ov;
    logic [31:0] e_m, e_i, e_d;
    logic [31:0] last_in_tick, last_out_tick;

    always @(posedge clk) begin
        bit          fin, was_open, eof_pre;
        int          nin_pre;
        logic [31:0] acc;
        if (in_start) last_in_tick = tick;
        if (out_end)  last_out_tick = tick;
        if (rst) begin
            m_open = 0; m_eof = 0; m_q.delete(); m_nout = 0; m_start = 0; m_last = 0;
            e_v = 0; e_uf = 0; e_ov = 0; e_m = 0; e_i = 0; e_d = 0;
        end else begin
            fin      = m_open && m_eof && (m_nout == m_q.size());
            was_open = m_open;
            eof_pre  = m_eof;
            nin_pre  = m_q.size();
            e_v      = fin;
            if (fin) begin
                acc = 0;
                foreach (m_q[i]) acc = ((m_q[i] > acc) ? m_q[i] : acc) + CELL;
                e_m = m_last - m_start;
                e_i = acc;
                if (e_m < acc) begin e_d = 0; e_uf = 1; end
                else begin e_d = e_m - acc; e_uf = 0; end
                m_open = 0;
            end
            if (out_end && was_open && m_nout != nin_pre) begin
                m_nout++;
                m_last = tick;
            end
            if (in_start && in_sof) begin
                if (was_open) e_ov = 1;
                else begin
                    m_open = 1; m_start = tick; m_q.delete(); m_q.push_back(32'd0);
                    m_eof = in_eof; m_nout = 0;
                end
            end else if (in_start && was_open && !eof_pre) begin
                m_q.push_back(tick - m_start);
                if (in_eof) m_eof = 1;
            end
        end
    end

    task automatic vec_cmp(input string who, input logic v, input logic [31:0] m,
                           input logic [31:0] i, input logic [31:0] d,
                           input logic uf, input logic ov);
        vectors++;
        if (v !== e_v || ov !== e_ov || m !== e_m || i !== e_i || d !== e_d || uf !== e_uf) begin
            fails++;
            $display("FAIL R1/R2/R3/R6/R7/R8 %s: got v=%0b m=%0d i=%0d d=%0d uf=%0b ov=%0b exp v=%0b m=%0d i=%0d d=%0d uf=%0b ov=%0b",
                     who, v, m, i, d, uf, ov, e_v, e_m, e_i, e_d, e_uf, e_ov);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            vec_cmp("fast", a_v, a_m, a_i, a_d, a_uf, a_ov);
            vec_cmp("slow", b_v, b_m, b_i, b_d, b_uf, b_ov);
        end
    end

    // result capture for directed checks
    int          cap_cnt = 0;
    logic [31:0] c_m, c_i, c_d, cb_d;
    logic        c_uf;
    always @(negedge clk) begin
        if (a_v) begin
            cap_cnt <= cap_cnt + 1;
            c_m <= a_m; c_i <= a_i; c_d <= a_d; c_uf <= a_uf;
        end
        if (b_v) cb_d <= b_d;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic sof, input logic eof, input logic oe);
        @(negedge clk);
        in_start = s; in_sof = sof; in_eof = eof; out_end = oe;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0);
    endtask

    task automatic expect_res(input string tag, input int base_cnt, input logic [31:0] m,
                              input logic [31:0] i, input logic [31:0] d, input logic uf);
        chk(cap_cnt == base_cnt + 1, {tag, " pulse count"}, cap_cnt, base_cnt + 1);
        chk(c_m == m,  {tag, " measured"},  c_m, m);
        chk(c_i == i,  {tag, " ideal"},     c_i, i);
        chk(c_d == d,  {tag, " device"},    c_d, d);
        chk(c_uf == uf, {tag, " underflow"}, c_uf, uf);
    endtask

    task automatic lilo_chk(input string tag);
        logic [31:0] exp;
        exp = last_out_tick - (last_in_tick + 32'd4);
        chk(cb_d == exp, tag, cb_d, exp);
    endtask

    initial begin
        int base;
        logic [31:0] lf;
        #(200000 * 20);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int base;
        logic [31:0] lf;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(a_v == 0 && a_ov == 0 && a_uf == 0, "R9 flags after reset", {a_v, a_ov, a_uf}, 0);
        chk(a_m == 0 && a_i == 0 && a_d == 0, "R9 results after reset", a_m | a_i | a_d, 0);

        // S1: arrivals 0,5 outputs 6,12; spans tick wrap (R10); R4 ideal 9
        base = cap_cnt;
        step(1, 1, 0, 0); idle(4); step(1, 0, 1, 0); step(0, 0, 0, 1); idle(5); step(0, 0, 0, 1);
        // R6: closing end sampled at edge k, pulse after edge k+1
        @(negedge clk); in_start = 0; out_end = 0;
        chk(a_v == 0, "R6 no pulse one cycle after last end", a_v, 0);
        @(negedge clk);
        chk(a_v == 1, "R6 pulse two edges after last end", a_v, 1);
        idle(2);
        expect_res("R4 R1 R2 R10 gap5", base, 12, 9, 3, 0);
        lilo_chk("R5 slow input gap5");

        // S2: arrivals 0,2 outputs 5,9 -> ideal 8 (R4)
        base = cap_cnt;
        step(1, 1, 0, 0); idle(1); step(1, 0, 1, 0); idle(2); step(0, 0, 0, 1); idle(3); step(0, 0, 0, 1);
        idle(4);
        expect_res("R4 gap2", base, 9, 8, 1, 0);

        // S3: single-cell frame, output at 6
        base = cap_cnt;
        step(1, 1, 1, 0); idle(5); step(0, 0, 0, 1); idle(4);
        expect_res("R1 single cell", base, 6, 4, 2, 0);
        lilo_chk("R5 single cell");

        // S4: outputs earlier than the ideal device -> saturate (R3)
        base = cap_cnt;
        step(1, 1, 0, 0); idle(3); step(0, 0, 0, 1); step(1, 0, 1, 0); idle(1); step(0, 0, 0, 1);
        idle(4);
        expect_res("R3 underflow", base, 7, 9, 0, 1);

        // S5: three cells at 0,1,10 outputs at 3,6,15 -> ideal 14
        base = cap_cnt;
        step(1, 1, 0, 0); step(1, 0, 0, 0); idle(1); step(0, 0, 0, 1); idle(2); step(0, 0, 0, 1);
        idle(3); step(1, 0, 1, 0); idle(4); step(0, 0, 0, 1); idle(4);
        expect_res("R1 three cells", base, 15, 14, 1, 0);
        lilo_chk("R5 three cells");

        // S6: stray strobes ignored (R8)
        base = cap_cnt;
        step(1, 0, 0, 0); step(0, 0, 0, 1); idle(3);
        chk(cap_cnt == base, "R8 stray strobes give no pulse", cap_cnt, base);
        step(1, 1, 1, 0); step(1, 0, 0, 0); idle(4); step(0, 0, 0, 1); step(0, 0, 0, 1); idle(4);
        expect_res("R8 cell after eof and extra end", base, 6, 4, 2, 0);

        // S7: start during open frame (R7)
        base = cap_cnt;
        chk(a_ov == 0, "R7 no overlap yet", a_ov, 0);
        step(1, 1, 0, 0); idle(1); step(1, 1, 0, 0); idle(2); step(1, 0, 1, 0); step(0, 0, 0, 1);
        idle(5); step(0, 0, 0, 1); idle(4);
        chk(a_ov == 1, "R7 overlap set", a_ov, 1);
        expect_res("R7 extra start not counted", base, 12, 9, 3, 0);
        idle(3);
        chk(a_ov == 1, "R7 overlap sticky", a_ov, 1);

        // R9: reset clears the sticky flag
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(a_ov == 0, "R9 overlap cleared by reset", a_ov, 0);

        // pseudo-random phase, compared each clock against the model
        lf = 32'h1234_5678;
        for (int n = 0; n < 4000; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(lf[1:0] == 2'b00, lf[5:3] == 3'b000, lf[7:6] == 2'b00, lf[9:8] != 2'b00);
        end
        idle(10);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule